// File: doc/BRIEF.md
# Dual-Tone Alert Duration Qualifier

This block sits behind a pair of tone filters in a caller-identity receiver. It takes one flag that says the alert tone pair is present and decides whether the burst is a valid alert. In the tone-alert operating mode, the detect output follows the tone flag, but only once the tone has lasted long enough that a short burst cannot raise it. When the tone ends, the block checks how long the burst lasted. If that length falls inside the qualifying window, the active-low interrupt drops and stays low until the mode pins leave the tone-alert mode. The detect output can also be used as a near-end mute control while a burst is in progress.

Two pins, a power-down pin and a mode pin, pick the operating mode. The same pins choose where the detect and interrupt outputs come from. In the power-down modes and in the data-receive mode, the outputs come from the ring/line-reversal flag instead of the tone logic. Time is measured with a millisecond tick divided down from the clock. Whenever the block is outside the tone-alert mode, the burst timer, the detect register and the latched interrupt are all held clear.

Top module: `tone_alert_qual`

## Requirements
- R1: With power-down=0 and mode=0 (tone-alert mode), `det` is high only while `tone_hit` is high and the current burst has lasted at least ON_MS (46) ticks. `det` goes low within two clocks after `tone_hit` falls.
- R2: In tone-alert mode, a tone burst of 45 ms or less never raises `det`.
- R3: In tone-alert mode, `irq_n` goes low within two clocks after the end of a burst whose tick count is from WIN_LO_MS (65) to WIN_HI_MS (95) inclusive. An 80 ms burst must qualify.
- R4: Bursts whose length is outside the window (40 ms, 100 ms, 150 ms) leave `irq_n` high.
- R5: Once low in tone-alert mode, `irq_n` stays low while the mode remains tone-alert, including through later bursts of any length.
- R6: Any clock spent outside tone-alert mode clears the latched interrupt, the detect register and the burst timer. A burst that was interrupted by a mode change is timed only from re-entry.
- R7: With power-down=0 and mode=1 (data receive), `det` is low and `irq_n` is the inverse of `ring_hit`.
- R8: With power-down=1 and mode=0, `det` equals `ring_hit` and `irq_n` is the inverse of `ring_hit`.
- R9: With power-down=1 and mode=1, `det` equals `ring_hit` and `irq_n` stays released (high).
- R10: While `rst_n` is low and mode is tone-alert, `det` is low and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_hit | input | 1 | Dual tone present, from the upstream tone filters |
| ring_hit | input | 1 | Ring or line polarity reversal detected |
| zp | input | 1 | Power-down mode select |
| mode | input | 1 | Mode select (0 tone-alert / 1 data receive when zp=0) |
| det | output | 1 | Detect output routed by mode |
| irq_n | output | 1 | Active-low interrupt routed by mode, 1 = released |

## Verification
The assertions check the routing on every cycle: the ring/reversal paths in the three non-tone modes, the rule that `det` in tone-alert mode needs a tone that has already lasted long enough, the hold of a latched interrupt, and the clear on re-entry. Only the bench's scenarios can show which burst lengths qualify and which do not (40, 80, 100 and 150 ms). The bench also covers the 45 ms edge for `det` and a burst that is split by a trip out of tone-alert mode, because these depend on whole stretches of input history rather than on single-cycle relations.

// File: rtl/tone_alert_qual.sv
module tone_alert_qual #(
  parameter int TICK_DIV  = 50000,
  parameter int ON_MS     = 46,
  parameter int WIN_LO_MS = 65,
  parameter int WIN_HI_MS = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_hit,
  input  logic ring_hit,
  input  logic zp,
  input  logic mode,
  output logic det,
  output logic irq_n
);
  localparam int CAP = WIN_HI_MS + 1;
  localparam int CW  = $clog2(CAP + 1);
  localparam int PW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre;
  logic [CW-1:0] ms_cnt;
  logic          det_q;
  logic          alert;
  logic          tick;
  logic          tone_mode;
  logic          in_win;

  assign tick      = (pre == PW'(TICK_DIV - 1));
  assign tone_mode = !zp && !mode;
  assign in_win    = (ms_cnt >= CW'(WIN_LO_MS)) && (ms_cnt <= CW'(WIN_HI_MS));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) pre <= '0;
    else                pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tone_mode) begin
      ms_cnt <= '0;
      det_q  <= 1'b0;
      alert  <= 1'b0;
    end else begin
      det_q <= tone_hit && (ms_cnt >= CW'(ON_MS));
      if (tone_hit) begin
        if (tick && ms_cnt != CW'(CAP)) ms_cnt <= ms_cnt + 1'b1;
      end else begin
        if (in_win) alert <= 1'b1;
        ms_cnt <= '0;
      end
    end
  end

  assign det   = zp ? ring_hit : (mode ? 1'b0 : det_q);
  assign irq_n = zp ? (mode ? 1'b1 : ~ring_hit) : (mode ? ~ring_hit : ~alert);
endmodule

// File: rtl/tone_alert_qual_chk.sv
module tone_alert_qual_chk #(
  parameter int TICK_DIV = 50000,
  parameter int ON_MS    = 46
) (
  input logic clk,
  input logic rst_n,
  input logic tone_hit,
  input logic ring_hit,
  input logic zp,
  input logic mode,
  input logic det,
  input logic irq_n
);
  logic        tmode;
  logic [31:0] run;
  assign tmode = !zp && !mode;

  always_ff @(posedge clk) begin
    if (!rst_n || !tmode || !tone_hit) run <= '0;
    else if (run != 32'hFFFF_FFFF)     run <= run + 1;
  end

  p_det_needs_tone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && det) |-> $past(tone_hit));

  p_det_min_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && det) |-> (run >= 32'((ON_MS - 1) * TICK_DIV)));

  p_irq_at_tone_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && $past(tmode) && $fell(irq_n)) |-> !$past(tone_hit));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && $past(tmode) && !$past(irq_n)) |-> !irq_n);

  p_reentry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && !$past(tmode)) |-> (irq_n && !det));

  p_fsk_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!zp && mode) |-> (!det && irq_n == !ring_hit));

  p_zp_det_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zp |-> (det == ring_hit));

  p_zp_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zp && !mode) |-> (irq_n == !ring_hit));

  p_zp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zp && mode) |-> irq_n);
endmodule

bind tone_alert_qual tone_alert_qual_chk #(.TICK_DIV(TICK_DIV), .ON_MS(ON_MS)) u_chk (.*);

// File: tb/sim_tone_alert_qual.sv
`timescale 1ns/1ps
module sim_tone_alert_qual;
  localparam int DIV = 10;
  localparam int NV  = 4;
  localparam int BURST_MS [NV] = '{40, 80, 100, 150};
  localparam bit EXP_IRQ  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit EXP_DET  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, tone_hit = 1'b0, ring_hit = 1'b0, zp = 1'b0, mode = 1'b0;
  logic det, irq_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tone_alert_qual #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tone_hit(tone_hit), .ring_hit(ring_hit),
    .zp(zp), .mode(mode), .det(det), .irq_n(irq_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reenter;
    mode = 1'b1; cyc(3); mode = 1'b0; cyc(2);
  endtask

  task automatic burst(input int ms, input bit exp_det, input string tag);
    tone_hit = 1'b1;
    cyc(ms * DIV - 1);
    chk(det == exp_det, tag, det, exp_det);
    cyc(1);
    tone_hit = 1'b0;
    cyc(3);
    chk(det == 1'b0, tag, det, 0);
  endtask

  initial begin
    cyc(3);
    chk(det == 1'b0, "R10 det in reset", det, 0);
    chk(irq_n == 1'b1, "R10 irq_n in reset", irq_n, 1);
    rst_n = 1'b1;
    cyc(5);

    for (int i = 0; i < NV; i++) begin
      reenter();
      burst(BURST_MS[i], EXP_DET[i], "R1 R2 det during burst");
      chk(irq_n == !EXP_IRQ[i], EXP_IRQ[i] ? "R3 qualified burst" : "R4 out-of-window burst",
          irq_n, !EXP_IRQ[i]);
    end

    reenter();
    burst(45, 1'b0, "R2 45 ms burst det");
    chk(irq_n == 1'b1, "R2 45 ms burst irq_n", irq_n, 1);

    reenter();
    burst(80, 1'b1, "R1 det 80 ms");
    chk(irq_n == 1'b0, "R3 80 ms irq_n", irq_n, 0);
    burst(40, 1'b0, "R5 later short burst det");
    chk(irq_n == 1'b0, "R5 hold after short burst", irq_n, 0);
    burst(150, 1'b1, "R5 later long burst det");
    chk(irq_n == 1'b0, "R5 hold after long burst", irq_n, 0);

    ring_hit = 1'b0; mode = 1'b1; cyc(3);
    chk(irq_n == 1'b1 && det == 1'b0, "R7 fsk ring low", irq_n, 1);
    ring_hit = 1'b1; cyc(1);
    chk(irq_n == 1'b0 && det == 1'b0, "R7 fsk ring high", irq_n, 0);
    ring_hit = 1'b0; mode = 1'b0; cyc(3);
    chk(irq_n == 1'b1, "R6 latch cleared on re-entry", irq_n, 1);

    tone_hit = 1'b1; cyc(60 * DIV);
    mode = 1'b1; cyc(3); mode = 1'b0;
    cyc(30 * DIV);
    tone_hit = 1'b0; cyc(3);
    chk(irq_n == 1'b1, "R6 split burst timed from re-entry", irq_n, 1);

    zp = 1'b1; mode = 1'b0; ring_hit = 1'b1; cyc(1);
    chk(det == 1'b1, "R8 det from ring", det, 1);
    chk(irq_n == 1'b0, "R8 irq_n from ring", irq_n, 0);
    ring_hit = 1'b0; cyc(1);
    chk(det == 1'b0 && irq_n == 1'b1, "R8 ring idle", irq_n, 1);

    mode = 1'b1; ring_hit = 1'b1; cyc(1);
    chk(det == 1'b1, "R9 det from ring", det, 1);
    chk(irq_n == 1'b1, "R9 irq_n released", irq_n, 1);
    tone_hit = 1'b1; cyc(5);
    chk(irq_n == 1'b1, "R9 tone ignored", irq_n, 1);
    tone_hit = 1'b0; ring_hit = 1'b0; zp = 1'b0; mode = 1'b0; cyc(2);

    rst_n = 1'b0; cyc(2);
    chk(det == 1'b0 && irq_n == 1'b1, "R10 reset again", irq_n, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule